// File: doc/BRIEF.md
# Jitter Tolerance Pattern Sequencer

This block feeds an 8b/10b encoder with a repeating test frame built to stress a clock and data recovery loop. Long runs of a low-transition-density byte pull the receiver's phase tracking one way. Long runs of a high-density byte then pull it the other way. Between the runs sit short sequences of transition bytes, placed so that the phase steps are as large as possible. The block presents one byte per cycle, with a control flag and a valid/ready handshake. The encoder and the serializer sit downstream.

A frame has five parts, in this order: idle ordered sets, a start delimiter, the payload, a CRC-32 of the payload, and an end delimiter. The payload comes from a run-length segment table of (byte, repeat count) entries. The two long runs and the short run of 0x7E bytes that follows the high run are parameters, so the payload length and its CRC follow those parameters. The encoder reports its running disparity through `disp_pos`. The sequencer sends extra idle sets until the start delimiter's comma will leave the disparity positive for the first payload byte.

The control state machine has six states:
- `ST_OFF`: silent.
- `ST_IDLE`: idle ordered sets.
- `ST_SOF`: start delimiter.
- `ST_PAYLOAD`: the run-length segments.
- `ST_CRC`: the four CRC bytes.
- `ST_EOF`: end delimiter.

It has seven transitions:
- T_START: `ST_OFF` to `ST_IDLE`, when `enable` is high.
- T_DELIM: `ST_IDLE` to `ST_SOF`, after enough idle sets and with disparity negative.
- T_BODY: `ST_SOF` to `ST_PAYLOAD`, when the delimiter is complete.
- T_TAIL: `ST_PAYLOAD` to `ST_CRC`, when the last segment byte is accepted.
- T_CLOSE: `ST_CRC` to `ST_EOF`.
- T_REPEAT: `ST_EOF` to `ST_IDLE`, when `enable` is high.
- T_STOP: `ST_EOF` to `ST_OFF`, when `enable` is low.

Top module: `jtpat_seq`

## Requirements
- R1: During reset and while `enable` has stayed low since reset, `out_valid` is 0.
- R2: A frame consists of IDLE_SETS idle sets (K 0xBC, then 0x95, 0xB5, 0xB5), a start delimiter (K 0xBC, then 0xB5, 0x56, 0x56), the payload, four CRC bytes, and an end delimiter (K 0xBC, then 0x95, 0xD5, 0xD5). With default parameters and negative disparity, the frame is 264 bytes long.
- R3: The payload is, in order: LOW_RUN × 0x7E; then 0x74, 0x7E, 0xAB; then HIGH_RUN × 0xB5; then 0x5E, 0x4A; then TAIL_RUN × 0x7E; then 0xFE. With defaults (167, 51, 4) this is 228 bytes.
- R4: The CRC bytes are computed over the payload bytes only. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. The bytes are sent least significant first.
- R5: `out_k` is 1 only on byte 0 of each four-byte ordered set, and there the data is 0xBC. No byte of the payload or the CRC carries `out_k`.
- R6: The sequencer samples `disp_pos` (1 = positive running disparity) when the last byte of each idle set, from the IDLE_SETS-th set on, is accepted. If the sample is 1, another idle set follows in place of the start delimiter.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_k` and `frame_start` hold, and no byte is lost or repeated in the accepted stream.
- R8: Frames follow back to back with no gap while `enable` stays high. `frame_start` is 1 exactly on the first idle byte of each frame.
- R9: If `enable` falls mid-frame, the frame completes through its end delimiter, and then `out_valid` goes low. A later rise of `enable` starts a complete new frame.
- R10: Changing LOW_RUN, HIGH_RUN or TAIL_RUN changes the run lengths, and the CRC follows the new payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run frames continuously while high |
| disp_pos | input | 1 | Encoder running disparity is positive |
| out_ready | input | 1 | Encoder accepts the presented byte |
| out_valid | output | 1 | A byte is presented |
| out_data | output | 8 | Byte value |
| out_k | output | 1 | Byte is a control character |
| frame_start | output | 1 | First idle byte of a frame |

## Verification
Two events can fall in the same cycle and are the interesting collisions. A backpressure stall can coincide with a frame boundary: the last idle byte, where the disparity decision is taken, or the last payload byte, where the run-length walk ends. The bench drives an irregular ready pattern across a whole frame so that stalls land on these boundaries. It then checks that every held byte stays stable and that the accepted stream still matches the arithmetically built frame and CRC. A disparity input held high across several idle-set ends, and an enable drop while a frame is running, check that the extra idle sets and the clean stop happen at the byte counts computed in the bench.

// File: rtl/jtpat_pkg.sv
package jtpat_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_SOF,
        ST_PAYLOAD,
        ST_CRC,
        ST_EOF
    } phase_t;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam int NUM_SEG = 9;

    localparam logic [7:0] SPARSE_BYTE = 8'h7E;
    localparam logic [7:0] DENSE_BYTE  = 8'hB5;

    // Byte idx of a four-byte ordered set for a delimiter phase.
    function automatic logic [7:0] set_byte(phase_t ph, logic [1:0] idx);
        logic [7:0] b;
        b = COMMA_BYTE;
        if (idx != 2'd0) begin
            case (ph)
                ST_SOF:  b = (idx == 2'd1) ? 8'hB5 : 8'h56;
                ST_EOF:  b = (idx == 2'd1) ? 8'h95 : 8'hD5;
                default: b = (idx == 2'd1) ? 8'h95 : 8'hB5;
            endcase
        end
        return b;
    endfunction

    // One byte step of the reflected CRC-32.
    function automatic logic [31:0] crc32_next(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/jtpat_segtab.sv
module jtpat_segtab
    import jtpat_pkg::*;
#(
    parameter int LOW_RUN  = 167,
    parameter int HIGH_RUN = 51,
    parameter int TAIL_RUN = 4,
    parameter int SEG_W    = 4,
    parameter int CNT_W    = 8
) (
    input  logic [SEG_W-1:0] seg_idx,
    output logic [7:0]       seg_byte,
    output logic [CNT_W-1:0] seg_len
);

    localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEN_LOW  = CNT_W'(LOW_RUN);
    localparam logic [CNT_W-1:0] LEN_HIGH = CNT_W'(HIGH_RUN);
    localparam logic [CNT_W-1:0] LEN_TAIL = CNT_W'(TAIL_RUN);

    // Segment order is behaviour: transition bytes sit between the runs.
    always_comb begin
        seg_byte = SPARSE_BYTE;
        seg_len  = LEN_ONE;
        unique case (int'(seg_idx))
            0: begin seg_byte = SPARSE_BYTE; seg_len = LEN_LOW;  end
            1: begin seg_byte = 8'h74;       seg_len = LEN_ONE;  end
            2: begin seg_byte = SPARSE_BYTE; seg_len = LEN_ONE;  end
            3: begin seg_byte = 8'hAB;       seg_len = LEN_ONE;  end
            4: begin seg_byte = DENSE_BYTE;  seg_len = LEN_HIGH; end
            5: begin seg_byte = 8'h5E;       seg_len = LEN_ONE;  end
            6: begin seg_byte = 8'h4A;       seg_len = LEN_ONE;  end
            7: begin seg_byte = SPARSE_BYTE; seg_len = LEN_TAIL; end
            8: begin seg_byte = 8'hFE;       seg_len = LEN_ONE;  end
            default: begin seg_byte = SPARSE_BYTE; seg_len = LEN_ONE; end
        endcase
    end

endmodule

// File: rtl/jtpat_runlen.sv
module jtpat_runlen
    import jtpat_pkg::*;
#(
    parameter int LOW_RUN  = 167,
    parameter int HIGH_RUN = 51,
    parameter int TAIL_RUN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    output logic [7:0] seg_byte,
    output logic       run_last
);

    localparam int MAX_LH  = (LOW_RUN > HIGH_RUN) ? LOW_RUN : HIGH_RUN;
    localparam int MAX_RUN = (MAX_LH > TAIL_RUN) ? MAX_LH : TAIL_RUN;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);
    localparam int SEG_W   = $clog2(NUM_SEG);
    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEG - 1);

    logic [SEG_W-1:0] seg_q;
    logic [CNT_W-1:0] rep_q;
    logic [CNT_W-1:0] seg_len;
    logic             rep_last;

    jtpat_segtab #(
        .LOW_RUN  (LOW_RUN),
        .HIGH_RUN (HIGH_RUN),
        .TAIL_RUN (TAIL_RUN),
        .SEG_W    (SEG_W),
        .CNT_W    (CNT_W)
    ) u_tab (
        .seg_idx  (seg_q),
        .seg_byte (seg_byte),
        .seg_len  (seg_len)
    );

    assign rep_last = (rep_q == seg_len - CNT_W'(1));
    assign run_last = rep_last && (seg_q == SEG_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seg_q <= '0;
            rep_q <= '0;
        end else if (step) begin
            if (rep_last) begin
                rep_q <= '0;
                seg_q <= (seg_q == SEG_LAST) ? '0 : seg_q + SEG_W'(1);
            end else begin
                rep_q <= rep_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/jtpat_crc32.sv
module jtpat_crc32
    import jtpat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= 32'hFFFF_FFFF;
        else if (step)      crc <= crc32_next(crc, din);
    end

endmodule

// File: rtl/jtpat_seq.sv
module jtpat_seq
    import jtpat_pkg::*;
#(
    parameter int LOW_RUN   = 167,
    parameter int HIGH_RUN  = 51,
    parameter int TAIL_RUN  = 4,
    parameter int IDLE_SETS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       disp_pos,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_k,
    output logic       frame_start
);

    localparam int SETS_W = $clog2(IDLE_SETS + 1);
    localparam logic [SETS_W-1:0] SETS_LAST = SETS_W'(IDLE_SETS - 1);
    localparam logic [SETS_W-1:0] SETS_MAX  = '1;

    phase_t            state_q, state_d;
    logic [1:0]        pos_q;
    logic [SETS_W-1:0] sets_q;
    logic              accept, set_end;
    logic              run_clear, run_step, run_last, crc_init;
    logic [7:0]        seg_byte;
    logic [31:0]       crc_q, crc_fin;

    assign accept    = out_valid && out_ready;
    assign set_end   = accept && (pos_q == 2'd3);
    assign run_clear = (state_q != ST_PAYLOAD);
    assign run_step  = accept && (state_q == ST_PAYLOAD);
    assign crc_init  = (state_q == ST_SOF);
    assign crc_fin   = ~crc_q;

    jtpat_runlen #(
        .LOW_RUN  (LOW_RUN),
        .HIGH_RUN (HIGH_RUN),
        .TAIL_RUN (TAIL_RUN)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (run_clear),
        .step     (run_step),
        .seg_byte (seg_byte),
        .run_last (run_last)
    );

    jtpat_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .step  (run_step),
        .din   (seg_byte),
        .crc   (crc_q)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (enable) state_d = ST_IDLE;
            ST_IDLE:    if (set_end && sets_q >= SETS_LAST && !disp_pos) state_d = ST_SOF;
            ST_SOF:     if (set_end) state_d = ST_PAYLOAD;
            ST_PAYLOAD: if (accept && run_last) state_d = ST_CRC;
            ST_CRC:     if (set_end) state_d = ST_EOF;
            ST_EOF:     if (set_end) state_d = enable ? ST_IDLE : ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Byte position within an ordered set, and idle-set count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= 2'd0;
            sets_q <= '0;
        end else begin
            if (state_q == ST_OFF)                       pos_q <= 2'd0;
            else if (accept && state_q != ST_PAYLOAD)    pos_q <= pos_q + 2'd1;

            if (state_q != ST_IDLE)                      sets_q <= '0;
            else if (set_end && sets_q != SETS_MAX)      sets_q <= sets_q + SETS_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b1;
        out_k     = 1'b0;
        out_data  = 8'h00;
        unique case (state_q)
            ST_OFF: begin
                out_valid = 1'b0;
            end
            ST_IDLE, ST_SOF, ST_EOF: begin
                out_data = set_byte(state_q, pos_q);
                out_k    = (pos_q == 2'd0);
            end
            ST_PAYLOAD: begin
                out_data = seg_byte;
            end
            ST_CRC: begin
                out_data = crc_fin[8*pos_q +: 8];
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign frame_start = (state_q == ST_IDLE) && (sets_q == '0) && (pos_q == 2'd0);

endmodule

// File: rtl/jtpat_seq_chk.sv
module jtpat_seq_chk
    import jtpat_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       disp_pos,
    input logic       out_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_k,
    input logic       frame_start,
    input phase_t     state_q
);

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_k) && $stable(frame_start)); // R7

    AST_K_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_k |-> out_data == COMMA_BYTE); // R5

    AST_NO_K_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (state_q == ST_PAYLOAD || state_q == ST_CRC) |-> !out_k); // R5

    AST_SOF_NEEDS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOF && $past(state_q) == ST_IDLE) |-> !$past(disp_pos)); // R6

    AST_FS_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> out_valid && out_k); // R8

    AST_BODY_AFTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && $past(state_q) != ST_PAYLOAD) |-> $past(state_q) == ST_SOF); // R2

endmodule

bind jtpat_seq jtpat_seq_chk u_chk (.*);

// File: tb/jtpat_seq_test.sv
`timescale 1ns/1ps
module jtpat_seq_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, enable, disp_pos, out_ready;
    logic out_valid, out_k, frame_start;
    logic [7:0] out_data;
    logic s_valid, s_k, s_fs;
    logic [7:0] s_data;

    jtpat_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .disp_pos(disp_pos),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_k(out_k), .frame_start(frame_start)
    );

    jtpat_seq #(.LOW_RUN(5), .HIGH_RUN(3), .TAIL_RUN(2)) uut_s (
        .clk(clk), .rst_n(rst_n), .enable(1'b1), .disp_pos(1'b0),
        .out_ready(1'b1), .out_valid(s_valid), .out_data(s_data),
        .out_k(s_k), .frame_start(s_fs)
    );

    int nchk = 0;
    int nfail = 0;

    logic [8:0] cap_a [0:4095];
    logic       fs_a  [0:4095];
    int         n_a = 0;
    logic [8:0] cap_s [0:4095];
    logic       fs_s  [0:4095];
    int         n_s = 0;
    logic [8:0] held;
    logic       held_fs;
    logic       holding = 1'b0;

    // Sample just before each rising edge; inputs change at negedge + 1 ns.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (holding) begin
                nchk++;
                if (!(out_valid && {out_k, out_data} == held && frame_start == held_fs)) begin
                    nfail++;
                    $display("FAIL R7 stall hold: got %h expected %h", {out_k, out_data}, held);
                end
            end
            holding = out_valid && !out_ready;
            held    = {out_k, out_data};
            held_fs = frame_start;
            if (out_valid && out_ready && n_a < 4096) begin
                cap_a[n_a] = {out_k, out_data};
                fs_a[n_a]  = frame_start;
                n_a++;
            end
            if (s_valid && n_s < 4096) begin
                cap_s[n_s] = {s_k, s_data};
                fs_s[n_s]  = s_fs;
                n_s++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

    logic [8:0] exp_f [0:511];
    int exp_len, pay_lo, pay_hi;

    task automatic put(input logic [8:0] v);
        exp_f[exp_len] = v;
        exp_len++;
    endtask

    task automatic put_set(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        put({1'b1, 8'hBC}); put({1'b0, a}); put({1'b0, b}); put({1'b0, c});
    endtask

    task automatic build(input int low, input int high, input int tail, input int nidle);
        logic [31:0] c;
        exp_len = 0;
        for (int i = 0; i < nidle; i++) put_set(8'h95, 8'hB5, 8'hB5);
        put_set(8'hB5, 8'h56, 8'h56);
        pay_lo = exp_len;
        for (int i = 0; i < low; i++) put({1'b0, 8'h7E});
        put({1'b0, 8'h74}); put({1'b0, 8'h7E}); put({1'b0, 8'hAB});
        for (int i = 0; i < high; i++) put({1'b0, 8'hB5});
        put({1'b0, 8'h5E}); put({1'b0, 8'h4A});
        for (int i = 0; i < tail; i++) put({1'b0, 8'h7E});
        put({1'b0, 8'hFE});
        pay_hi = exp_len;
        c = 32'hFFFF_FFFF;
        for (int i = pay_lo; i < pay_hi; i++) c = crc_step(c, exp_f[i][7:0]);
        c = ~c;
        put({1'b0, c[7:0]}); put({1'b0, c[15:8]}); put({1'b0, c[23:16]}); put({1'b0, c[31:24]});
        put_set(8'h95, 8'hD5, 8'hD5);
    endtask

    task automatic check_frame(input bit sel, input int st, input int low, input int high,
                               input int tail, input int nidle, input string tag);
        int bad_d, bad_p, bad_c, bad_k, bad_f, avail;
        logic [8:0] g;
        logic f;
        bad_d = 0; bad_p = 0; bad_c = 0; bad_k = 0; bad_f = 0;
        build(low, high, tail, nidle);
        avail = sel ? n_s : n_a;
        chk(avail >= st + exp_len, {"R2 frame captured ", tag}, avail, st + exp_len);
        for (int i = 0; i < exp_len; i++) begin
            g = sel ? cap_s[st + i] : cap_a[st + i];
            f = sel ? fs_s[st + i]  : fs_a[st + i];
            if (i >= pay_lo && i < pay_hi)          begin if (g !== exp_f[i]) bad_p++; end
            else if (i >= pay_hi && i < pay_hi + 4) begin if (g !== exp_f[i]) bad_c++; end
            else                                    begin if (g !== exp_f[i]) bad_d++; end
            if (i >= pay_lo && i < pay_hi + 4 && g[8] !== 1'b0) bad_k++;
            if (f !== (i == 0)) bad_f++;
        end
        chk(bad_d == 0, {"R2 delimiters ", tag}, bad_d, 0);
        chk(bad_p == 0, {"R3 payload ", tag}, bad_p, 0);
        chk(bad_c == 0, {"R4 crc ", tag}, bad_c, 0);
        chk(bad_k == 0, {"R5 no K inside frame ", tag}, bad_k, 0);
        chk(bad_f == 0, {"R8 frame_start placement ", tag}, bad_f, 0);
        if (avail > st + exp_len) begin
            f = sel ? fs_s[st + exp_len] : fs_a[st + exp_len];
            chk(f === 1'b1, {"R8 next frame back to back ", tag}, int'(f), 1);
        end
    endtask

    task automatic wait_cap(input int n);
        while (n_a < n) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int cyc;
        rst_n = 1'b0; enable = 1'b0; disp_pos = 1'b0; out_ready = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk(!out_valid && !s_valid, "R1 quiet in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            chk(!out_valid, "R1 quiet while disabled", int'(out_valid), 0);
        end

        // Two frames back to back, full speed.
        enable = 1'b1;
        wait_cap(529);
        check_frame(1'b0, 0, 167, 51, 4, 6, "f0");
        check_frame(1'b0, 264, 167, 51, 4, 6, "f1");
        chk(fs_a[264] === 1'b1, "R2 default frame length 264", 264, 264);

        // Irregular backpressure across a frame.
        cyc = 0;
        while (n_a < 793) begin
            @(negedge clk);
            #1;
            cyc++;
            out_ready = ((cyc % 3) != 0) && ((cyc % 7) != 3);
        end
        out_ready = 1'b1;
        check_frame(1'b0, 528, 167, 51, 4, 6, "R7 stalled frame");

        // Positive disparity over idle-set ends 6..10; 11 sets expected.
        disp_pos = 1'b1;
        wait_cap(792 + 40);
        disp_pos = 1'b0;
        wait_cap(1076 + 1);
        check_frame(1'b0, 792, 167, 51, 4, 11, "R6 padded frame");
        chk(cap_a[792 + 41] == {1'b0, 8'h95}, "R6 eleventh set is idle", int'(cap_a[792 + 41]), 9'h095);
        chk(cap_a[792 + 45] == {1'b0, 8'hB5}, "R6 SOF after eleventh set", int'(cap_a[792 + 45]), 9'h0B5);

        // Enable drops mid-frame: frame completes then stops.
        wait_cap(1076 + 100);
        enable = 1'b0;
        repeat (300) @(negedge clk);
        #1;
        chk(n_a == 1076 + 264, "R9 frame completes after enable drop", n_a, 1076 + 264);
        chk(!out_valid, "R9 silent after stop", int'(out_valid), 0);
        check_frame(1'b0, 1076, 167, 51, 4, 6, "R9 last frame");
        enable = 1'b1;
        wait_cap(1340 + 264);
        check_frame(1'b0, 1340, 167, 51, 4, 6, "R9 restarted frame");

        // Small run lengths: 16 payload bytes, 52 per frame.
        check_frame(1'b1, 0, 5, 3, 2, 6, "R10 small f0");
        check_frame(1'b1, 52, 5, 3, 2, 6, "R10 small f1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule